// File: doc/BRIEF.md
# Presettable Split Binary Up-Counter

This block is a four-bit binary up-counter made of two sections, each with its own clock input. A one-bit low section drives `q[0]` and toggles on every falling edge of `cpLow`. A three-bit high section drives `q[3:1]` and counts up on every falling edge of `cpHigh`. When `q[0]` is wired back to `cpHigh` outside the block, the two sections form one modulo-16 counter.

Two active-low level controls can override counting at any time. A master clear forces every output bit to zero. A parallel load copies `dataIn` into the counter. While the load stays low, the outputs follow the data inputs. After the load is released, the last loaded value is held until a counted edge arrives, so the block can also act as a four-bit latch.

Every input is sampled on a fast system clock `clk`, and edges on the section clocks are found from those samples. The block is therefore fully synchronous and suitable for synthesis.

Top module: `split_ripple_counter`

## Requirements
- R1: A falling edge of `cpLow` toggles `q[0]`. That edge leaves `q[3:1]` unchanged, and `q[0]` changes on no other input.
- R2: A falling edge of `cpHigh` adds one to `q[3:1]`, which is read as an unsigned number with `q[1]` as its least significant bit. That edge leaves `q[0]` unchanged.
- R3: While `masterRstN` is low, `q` is 4'b0000. This holds whatever the values of `loadN`, `dataIn` and both clocks.
- R4: While `masterRstN` is high and `loadN` is low, `q` equals `dataIn`. It follows every change of `dataIn`, and edges on `cpLow` and `cpHigh` have no effect.
- R5: When `loadN` returns high with no clock edge, `q` keeps the last loaded value.
- R6: The high section counts from 7 to 0 on a counted edge, and the low section goes from 1 to 0 on a counted edge.
- R7: With `q[0]` tied to `cpHigh`, successive falling edges of `cpLow` step `q` through the values 0 to 15 in binary order, and then back to 0.
- R8: A change of any input that is stable across one rising edge of `clk` appears on `q` at the second rising edge, not before. A rising edge on a section clock changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| sysRstN | input | 1 | Active-low synchronous reset of the sampling logic and the counter |
| masterRstN | input | 1 | Active-low master clear, level sensitive |
| loadN | input | 1 | Active-low parallel load, level sensitive |
| dataIn | input | 4 | Parallel data for the load |
| cpLow | input | 1 | Clock of the one-bit section, counts on its falling edge |
| cpHigh | input | 1 | Clock of the three-bit section, counts on its falling edge |
| q | output | 4 | Counter value; `q[0]` is the low section, `q[3:1]` is the high section |

## Verification
The low section is driven on its own, and so is the high section, so that an edge on one clock is seen to leave the other section alone. Both sections are also run up to their wrap points. A load is held low while both clocks toggle and the data changes, which separates a design that follows the data level from one that only captures it once or lets edges through. A master clear is applied in the middle of a count with the load also asserted, which shows the priority between the two. The fully cascaded 16-step run checks the carry from `q[0]` to the high section and its extra sampling delay. A cycle-exact probe and a rising-edge-only probe pin down the two-cycle latency and the edge polarity.

// File: rtl/split_counter_pkg.sv
package split_counter_pkg;
  localparam int LOW_W  = 1;
  localparam int HIGH_W = 3;
  localparam int CNT_W  = LOW_W + HIGH_W;

  typedef struct packed {
    logic clear;
    logic load;
    logic stepLow;
    logic stepHigh;
  } ctrlStrobes_t;
endpackage

// File: rtl/split_counter_ctrl.sv
module split_counter_ctrl
  import split_counter_pkg::*;
#(
  parameter int DATA_W = CNT_W
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              masterRstN,
  input  logic              loadN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              cpLow,
  input  logic              cpHigh,
  output ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] loadData
);
  localparam int NUM_CLK = 2;

  logic              rstSmp, loadSmp;
  logic [DATA_W-1:0] dataSmp;
  logic [NUM_CLK-1:0] clkNow, clkPrev, fallSeen;

  always_ff @(posedge clk) begin
    if (!sysRstN) begin
      rstSmp  <= 1'b0;
      loadSmp <= 1'b1;
      dataSmp <= '0;
    end else begin
      rstSmp  <= masterRstN;
      loadSmp <= loadN;
      dataSmp <= dataIn;
    end
  end

  for (genvar c = 0; c < NUM_CLK; c++) begin : g_edge
    logic rawClk;
    assign rawClk = (c == 0) ? cpLow : cpHigh;
    always_ff @(posedge clk) begin
      if (!sysRstN) begin
        clkNow[c]  <= 1'b0;
        clkPrev[c] <= 1'b0;
      end else begin
        clkNow[c]  <= rawClk;
        clkPrev[c] <= clkNow[c];
      end
    end
    assign fallSeen[c] = clkPrev[c] & ~clkNow[c];
  end

  always_comb begin
    strobes.clear    = ~rstSmp;
    strobes.load     = rstSmp & ~loadSmp;
    strobes.stepLow  = rstSmp & loadSmp & fallSeen[0];
    strobes.stepHigh = rstSmp & loadSmp & fallSeen[1];
  end

  assign loadData = dataSmp;

  AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!sysRstN)
    $onehot0({strobes.clear, strobes.load})); // R3
  AST_STEP_MASKED: assert property (@(posedge clk) disable iff (!sysRstN)
    (strobes.clear || strobes.load) |-> !(strobes.stepLow || strobes.stepHigh)); // R4
endmodule

// File: rtl/split_counter_datapath.sv
module split_counter_datapath
  import split_counter_pkg::*;
#(
  parameter int LW = LOW_W,
  parameter int HW = HIGH_W
) (
  input  logic             clk,
  input  logic             sysRstN,
  input  ctrlStrobes_t     strobes,
  input  logic [LW+HW-1:0] loadData,
  output logic [LW+HW-1:0] q
);
  localparam int TOTAL_W = LW + HW;

  logic [LW-1:0] lowCnt;
  logic [HW-1:0] highCnt;

  always_ff @(posedge clk) begin
    if (!sysRstN || strobes.clear) begin
      lowCnt <= '0;
    end else if (strobes.load) begin
      lowCnt <= loadData[LW-1:0];
    end else if (strobes.stepLow) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!sysRstN || strobes.clear) begin
      highCnt <= '0;
    end else if (strobes.load) begin
      highCnt <= loadData[TOTAL_W-1:LW];
    end else if (strobes.stepHigh) begin
      highCnt <= highCnt + 1'b1;
    end
  end

  assign q = {highCnt, lowCnt};

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!sysRstN)
    strobes.clear |=> (q == '0)); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!sysRstN)
    strobes.load |=> (q == $past(loadData))); // R4
  AST_LOW_TOGGLE: assert property (@(posedge clk) disable iff (!sysRstN)
    (!strobes.clear && !strobes.load && strobes.stepLow) |=> (q[0] != $past(q[0]))); // R1
  AST_HIGH_WRAP: assert property (@(posedge clk) disable iff (!sysRstN)
    (!strobes.clear && !strobes.load && strobes.stepHigh && (highCnt == '1)) |=> (highCnt == '0)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!sysRstN)
    (!strobes.clear && !strobes.load && !strobes.stepLow && !strobes.stepHigh) |=> $stable(q)); // R5
endmodule

// File: rtl/split_ripple_counter.sv
module split_ripple_counter
  import split_counter_pkg::*;
(
  input  logic             clk,
  input  logic             sysRstN,
  input  logic             masterRstN,
  input  logic             loadN,
  input  logic [CNT_W-1:0] dataIn,
  input  logic             cpLow,
  input  logic             cpHigh,
  output logic [CNT_W-1:0] q
);
  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] loadData;

  split_counter_ctrl #(.DATA_W(CNT_W)) u_ctrl (
    .clk(clk), .sysRstN(sysRstN), .masterRstN(masterRstN), .loadN(loadN),
    .dataIn(dataIn), .cpLow(cpLow), .cpHigh(cpHigh),
    .strobes(strobes), .loadData(loadData)
  );

  split_counter_datapath #(.LW(LOW_W), .HW(HIGH_W)) u_dp (
    .clk(clk), .sysRstN(sysRstN), .strobes(strobes),
    .loadData(loadData), .q(q)
  );
endmodule

// File: tb/sim_split_ripple_counter.sv
module sim_split_ripple_counter;
  logic       clk = 1'b0;
  logic       sysRstN = 1'b0;
  logic       masterRstN = 1'b1;
  logic       loadN = 1'b1;
  logic [3:0] dataIn = 4'h0;
  logic       cpLow = 1'b0;
  logic       cpHighDrv = 1'b0;
  logic       cascade = 1'b0;
  logic       cpHigh;
  logic [3:0] q;

  int errors = 0;
  int checks = 0;
  bit allDone = 1'b0;

  typedef struct {
    logic [3:0] expQ;
    string      tag;
  } item_t;
  item_t sbQueue[$];

  always #2 clk = ~clk;

  assign cpHigh = cascade ? q[0] : cpHighDrv;

  split_ripple_counter u0 (
    .clk(clk), .sysRstN(sysRstN), .masterRstN(masterRstN), .loadN(loadN),
    .dataIn(dataIn), .cpLow(cpLow), .cpHigh(cpHigh), .q(q)
  );

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_q(input logic [3:0] e, input string tag);
    item_t it;
    it.expQ = e;
    it.tag  = tag;
    sbQueue.push_back(it);
    wait (sbQueue.size() == 0);
  endtask

  task automatic direct_check(input logic [3:0] e, input string tag);
    #1;
    checks++;
    if (q !== e) begin
      errors++;
      $display("FAIL %s: q=%h expected=%h", tag, q, e);
    end
  endtask

  task automatic pulse_low();
    cpLow = 1'b1; settle(3);
    cpLow = 1'b0; settle(5);
  endtask

  task automatic pulse_high();
    cpHighDrv = 1'b1; settle(3);
    cpHighDrv = 1'b0; settle(5);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (sbQueue.size() > 0) begin
        it = sbQueue.pop_front();
        checks++;
        if (q !== it.expQ) begin
          errors++;
          $display("FAIL %s: q=%h expected=%h", it.tag, q, it.expQ);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!allDone) begin
      errors++;
      checks++;
      $display("FAIL watchdog: q=%h expected=done", q);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    settle(3);
    sysRstN = 1'b1;
    settle(2);
    expect_q(4'h0, "reset state R3");

    // R1: low section alone
    pulse_low();
    expect_q(4'h1, "R1 low toggle");
    // R6: low wraps 1 -> 0, high untouched
    pulse_low();
    expect_q(4'h0, "R6 low wrap");

    // R2: high section alone
    pulse_high();
    expect_q(4'h2, "R2 high step");
    pulse_high();
    pulse_high();
    expect_q(4'h6, "R2 high count 3");

    // R8: rising edge only has no effect
    cpHighDrv = 1'b1; settle(5);
    expect_q(4'h6, "R8 rising edge ignored");
    // R8: latency, falling edge driven at a negedge
    cpHighDrv = 1'b0;
    @(negedge clk); direct_check(4'h6, "R8 not after one edge");
    @(negedge clk); direct_check(4'h8, "R8 after two edges");
    settle(3);

    // R3: clear mid-count with load asserted too
    pulse_low();
    expect_q(4'h9, "R1 count before clear");
    masterRstN = 1'b0; loadN = 1'b0; dataIn = 4'hB;
    settle(4);
    expect_q(4'h0, "R3 clear beats load");
    pulse_low();
    expect_q(4'h0, "R3 clock ignored under clear");
    masterRstN = 1'b1;
    settle(4);
    expect_q(4'hB, "R4 load after clear release");

    // R4: edges ignored, data followed while load low
    pulse_low();
    pulse_high();
    expect_q(4'hB, "R4 edges ignored during load");
    dataIn = 4'h3; settle(4);
    expect_q(4'h3, "R4 follows data");

    // R5: hold after release
    loadN = 1'b1; settle(2);
    dataIn = 4'hC; settle(6);
    expect_q(4'h3, "R5 latch hold");
    pulse_low();
    expect_q(4'h2, "R1 count after latch");

    // R6: high wraps 7 -> 0 with q0 untouched
    loadN = 1'b0; dataIn = 4'hF; settle(4);
    loadN = 1'b1; settle(4);
    pulse_high();
    expect_q(4'h1, "R6 high wrap");

    // R7: cascaded modulo-16 run
    masterRstN = 1'b0; settle(4);
    masterRstN = 1'b1; settle(4);
    cascade = 1'b1;
    settle(4);
    for (int i = 1; i <= 16; i++) begin
      pulse_low();
      expect_q(4'(i % 16), $sformatf("R7 cascade step %0d", i));
    end

    allDone = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule